// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block counts a 16-bit value down to zero at a rate taken from a slow reference pulse train (nominally 32.768 kHz, one pulse per `refTick` cycle). A 4-bit divider code picks how many reference pulses make one timer tick, always a power of two. Software loads the reload value one byte at a time, picks one-shot or free-run operation and whether the interrupt is enabled, then starts the timer with a control write.

When the count runs out, the timer flag is set and, if enabled, the interrupt output rises. In one-shot mode the timer stops at zero. In free-run mode the counter reloads at once but stays paused. It does not count again in either mode until software clears the flag by writing a 1 to the status strobe.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, `count` is 0 and `timerFlag`, `timerIrq` and `running` are all low.
- R2: With divider code c (`wrData[3:0]` on a `wrDivider` write), one tick occurs every 2^c reference pulses for c from 0 to 11; codes 12 to 15 all give 4096 pulses per tick. A start clears the prescaler phase, so the first tick comes after exactly that many pulses.
- R3: A `wrReloadLo` write stores `wrData` as reload bits 7:0, and a `wrReloadHi` write stores it as bits 15:8. An accepted start copies the full reload value into `count`.
- R4: A `wrControl` write with `wrData[0]`=1 and the flag clear starts the timer (`running` high). A write with `wrData[0]`=0 stops it, and `count` then holds through further reference pulses. Every control write latches free-run mode from `wrData[1]` and interrupt enable from `wrData[2]`.
- R5: While running with the flag clear, each tick lowers `count` by one. A tick taken when `count` is 1 (or 0) is the expiry and sets `timerFlag` on that same clock edge.
- R6: On expiry in one-shot mode, `count` becomes 0 and `running` falls.
- R7: On expiry in free-run mode, `count` reloads and `running` stays high. Ticks are ignored while the flag is set, and counting resumes after the flag is cleared.
- R8: A start write while the flag is set is ignored: `running` and `count` are unchanged.
- R9: A `wrStatus` write with `wrData[0]`=1 clears the flag. With `wrData[0]`=0 the write has no effect.
- R10: `timerIrq` is high exactly when the flag is set and the interrupt enable is high.
- R11: When an expiry and a flag-clear write fall in the same cycle, the flag ends set.
- R12: Writing the reload bytes while running does not change `count` until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle pulse per reference period |
| wrData | input | 8 | Write data for all strobes |
| wrReloadLo | input | 1 | Store low reload byte |
| wrReloadHi | input | 1 | Store high reload byte |
| wrDivider | input | 1 | Store divider code from wrData[3:0] |
| wrControl | input | 1 | Control write: bit0 start/stop, bit1 free-run, bit2 irq enable |
| wrStatus | input | 1 | Status write: bit0=1 clears the flag |
| count | output | 16 | Current counter value |
| timerFlag | output | 1 | Expiry flag |
| timerIrq | output | 1 | Interrupt request |
| running | output | 1 | Timer armed |

## Verification
The expiry of the count and a software write that clears the flag can land on the same clock edge. The bench first brings a free-run count to 1 with a divide-by-one prescaler. It then drives the final reference pulse together with a status write of 1 and requires the flag to stay set and the count to have reloaded. Around this case, constrained-random runs over divider code, reload value and mode compare the count partway through a period and the flag, count and run state at the exact pulse of expiry with values computed in the bench.

// File: rtl/prescaled_timer_pkg.sv
package prescaled_timer_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // copy reload into counter, clear prescaler phase
    logic dec;    // count down by one
    logic zero;   // force counter to zero
  } tmrStrobe_t;
endpackage

// File: rtl/prescaled_timer_datapath.sv
module prescaled_timer_datapath
  import prescaled_timer_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int DIV_W     = 4,
  parameter int MAX_SHIFT = 12,
  localparam int CNT_W    = 2 * BYTE_W,
  localparam int PRE_W    = MAX_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              wrReloadLo,
  input  logic              wrReloadHi,
  input  logic [DIV_W-1:0]  divIn,
  input  logic              wrDivider,
  input  tmrStrobe_t        str,
  output logic              tick,
  output logic              lastStep,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] reloadVal;
  logic [DIV_W-1:0] divCode;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  int               shiftSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
      divCode   <= '0;
    end else begin
      if (wrReloadLo) reloadVal[BYTE_W-1:0]     <= wrByte;
      if (wrReloadHi) reloadVal[CNT_W-1:BYTE_W] <= wrByte;
      if (wrDivider)  divCode                   <= divIn;
    end
  end

  // codes above MAX_SHIFT saturate at the largest division
  always_comb begin
    shiftSel = (int'(divCode) > MAX_SHIFT) ? MAX_SHIFT : int'(divCode);
    for (int i = 0; i < PRE_W; i++) preMask[i] = (i < shiftSel);
  end

  assign tick     = refTick && ((preCnt & preMask) == preMask);
  assign lastStep = (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)         preCnt <= '0;
    else if (str.load) preCnt <= '0;
    else if (refTick)  preCnt <= preCnt + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         count <= '0;
    else if (str.load) count <= reloadVal;
    else if (str.zero) count <= '0;
    else if (str.dec)  count <= count - CNT_W'(1);
  end

  // R5
  count_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(str.load) |-> (count <= $past(count)));

  // R2
  count_needs_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(refTick) && !$past(str.load)) |-> $stable(count));

  // R12
  reload_write_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrReloadLo || wrReloadHi) && !$past(str.load) && !$past(refTick)) |-> $stable(count));
endmodule

// File: rtl/prescaled_timer_ctrl.sv
module prescaled_timer_ctrl
  import prescaled_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] ctlBits,
  input  logic       wrControl,
  input  logic       wrStatus,
  input  logic       tick,
  input  logic       lastStep,
  output tmrStrobe_t str,
  output logic       timerFlag,
  output logic       timerIrq,
  output logic       running
);
  logic modeFree;
  logic irqEn;
  logic startReq;
  logic canRun;
  logic expire;

  assign startReq = wrControl && ctlBits[0];
  assign canRun   = running && !timerFlag;
  assign expire   = canRun && tick && lastStep;

  always_comb begin
    str.load = (startReq && !timerFlag) || (expire && modeFree);
    str.zero = expire && !modeFree;
    str.dec  = canRun && tick && !lastStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeFree  <= 1'b0;
      irqEn     <= 1'b0;
      running   <= 1'b0;
      timerFlag <= 1'b0;
    end else begin
      if (wrControl) begin
        modeFree <= ctlBits[1];
        irqEn    <= ctlBits[2];
        if (!ctlBits[0])     running <= 1'b0;
        else if (!timerFlag) running <= 1'b1;
      end else if (expire && !modeFree) begin
        running <= 1'b0;
      end
      // expiry wins over a clear in the same cycle
      if (expire)                      timerFlag <= 1'b1;
      else if (wrStatus && ctlBits[0]) timerFlag <= 1'b0;
    end
  end

  assign timerIrq = timerFlag && irqEn;

  // R5
  flag_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerFlag) |-> $past(running));

  // R9
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timerFlag) |-> $past(wrStatus && ctlBits[0]));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(timerFlag) && $past(!modeFree) && $past(!wrControl)) |-> !running);

  // R8
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(timerFlag) && $past(startReq)) |-> (running == $past(running)));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import prescaled_timer_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int DIV_W     = 4,
  parameter int MAX_SHIFT = 12,
  localparam int CNT_W    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrReloadLo,
  input  logic              wrReloadHi,
  input  logic              wrDivider,
  input  logic              wrControl,
  input  logic              wrStatus,
  output logic [CNT_W-1:0]  count,
  output logic              timerFlag,
  output logic              timerIrq,
  output logic              running
);
  tmrStrobe_t str;
  logic       tick;
  logic       lastStep;

  prescaled_timer_datapath #(
    .BYTE_W(BYTE_W), .DIV_W(DIV_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrByte(wrData),
    .wrReloadLo(wrReloadLo), .wrReloadHi(wrReloadHi),
    .divIn(wrData[DIV_W-1:0]), .wrDivider(wrDivider), .str(str),
    .tick(tick), .lastStep(lastStep), .count(count)
  );

  prescaled_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlBits(wrData[2:0]), .wrControl(wrControl),
    .wrStatus(wrStatus), .tick(tick), .lastStep(lastStep), .str(str),
    .timerFlag(timerFlag), .timerIrq(timerIrq), .running(running)
  );

  // R10
  irq_tracks_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq |-> timerFlag);
endmodule

// File: tb/prescaled_timer_tb.sv
`timescale 1ns/1ps
module prescaled_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic [7:0]  wrData = '0;
  logic        wrReloadLo = 1'b0, wrReloadHi = 1'b0, wrDivider = 1'b0;
  logic        wrControl = 1'b0, wrStatus = 1'b0;
  logic [15:0] count;
  logic        timerFlag, timerIrq, running;
  int          nCheck = 0;
  int          nFail = 0;

  always #2 clk = ~clk;

  prescaled_timer u_dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrData(wrData),
    .wrReloadLo(wrReloadLo), .wrReloadHi(wrReloadHi), .wrDivider(wrDivider),
    .wrControl(wrControl), .wrStatus(wrStatus), .count(count),
    .timerFlag(timerFlag), .timerIrq(timerIrq), .running(running)
  );

  function automatic int pulsesPerTick(input int code);
    return 1 << ((code > 12) ? 12 : code);
  endfunction

  function automatic int expCount(input int reload, input int code, input int pulses);
    return reload - pulses / pulsesPerTick(code);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nCheck++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      refTick = 1'b1;
      @(negedge clk);
    end
    refTick = 1'b0;
  endtask

  task automatic setReload(input int v);
    wrData = v[7:0]; wrReloadLo = 1'b1; @(negedge clk); wrReloadLo = 1'b0;
    wrData = v[15:8]; wrReloadHi = 1'b1; @(negedge clk); wrReloadHi = 1'b0;
  endtask

  task automatic setDiv(input int code);
    wrData = 8'(code); wrDivider = 1'b1; @(negedge clk); wrDivider = 1'b0;
  endtask

  task automatic ctrlWrite(input logic go, input logic free, input logic irqOn);
    wrData = {5'b0, irqOn, free, go}; wrControl = 1'b1; @(negedge clk); wrControl = 1'b0;
  endtask

  task automatic statusWrite(input logic bit0);
    wrData = {7'b0, bit0}; wrStatus = 1'b1; @(negedge clk); wrStatus = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1
    check("R1 count", count, 0);
    check("R1 flag", timerFlag, 0);
    check("R1 irq", timerIrq, 0);
    check("R1 running", running, 0);

    // one-shot, divide by one, irq on
    setReload(5); setDiv(0); ctrlWrite(1, 0, 1);
    check("R4 start running", running, 1);
    check("R3 load", count, 5);
    pulses(2);
    check("R5 decrement", count, 3);
    check("R10 irq before expiry", timerIrq, 0);
    pulses(3);
    check("R5 flag at expiry", timerFlag, 1);
    check("R6 count zero", count, 0);
    check("R6 stopped", running, 0);
    check("R10 irq", timerIrq, 1);
    // R8 start ignored while flagged
    ctrlWrite(1, 0, 1);
    check("R8 running", running, 0);
    check("R8 count", count, 0);
    // R9 write of 0 has no effect, 1 clears
    statusWrite(0);
    check("R9 zero write", timerFlag, 1);
    statusWrite(1);
    check("R9 clear", timerFlag, 0);
    check("R10 irq drops", timerIrq, 0);

    // R3 byte order, R12 reload write while running, R4 stop
    setReload(16'h1234); ctrlWrite(1, 0, 0);
    pulses(1);
    check("R3 two bytes", count, 16'h1233);
    setReload(16'h0002);
    check("R12 no effect", count, 16'h1233);
    pulses(1);
    check("R12 keeps counting", count, 16'h1232);
    ctrlWrite(0, 0, 0);
    pulses(3);
    check("R4 stop holds", count, 16'h1232);
    check("R4 stopped", running, 0);

    // R2 code 11 and saturated code 13
    setReload(1); setDiv(11); ctrlWrite(1, 0, 0);
    pulses(2047);
    check("R2 code11 early", timerFlag, 0);
    pulses(1);
    check("R2 code11 expiry", timerFlag, 1);
    statusWrite(1); setDiv(13); ctrlWrite(1, 0, 0);
    pulses(4095);
    check("R2 code13 early", timerFlag, 0);
    pulses(1);
    check("R2 code13 expiry", timerFlag, 1);
    statusWrite(1);

    // R7 free-run, irq off
    setReload(3); setDiv(2); ctrlWrite(1, 1, 0);
    pulses(12);
    check("R7 flag", timerFlag, 1);
    check("R7 reload", count, 3);
    check("R7 still running", running, 1);
    check("R10 irq masked", timerIrq, 0);
    pulses(8);
    check("R7 paused", count, 3);
    statusWrite(1);
    pulses(4);
    check("R7 resumed", count, 2);
    pulses(8);
    check("R7 second expiry", timerFlag, 1);

    // R11 expiry and clear in the same cycle
    setDiv(0); statusWrite(1);
    pulses(2);
    check("R11 setup", count, 1);
    refTick = 1'b1; wrData = 8'h01; wrStatus = 1'b1;
    @(negedge clk);
    refTick = 1'b0; wrStatus = 1'b0;
    check("R11 set wins", timerFlag, 1);
    check("R11 reloaded", count, 3);

    // random runs: R2 R5 R6 R7
    for (int it = 0; it < 20; it++) begin
      int code, rel, k, ppt;
      logic free;
      code = int'($urandom % 7);
      rel  = 1 + int'($urandom % 20);
      free = 1'($urandom % 2);
      ppt  = pulsesPerTick(code);
      k    = int'($urandom % (rel * ppt));
      statusWrite(1); setReload(rel); setDiv(code); ctrlWrite(1, free, 1);
      pulses(k);
      check("R2 random mid count", count, expCount(rel, code, k));
      check("R5 random no flag", timerFlag, 0);
      pulses(rel * ppt - k);
      check("R5 random flag", timerFlag, 1);
      check(free ? "R7 random count" : "R6 random count", count, free ? rel : 0);
      check("R6 R7 random running", running, free ? 1 : 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end
endmodule